// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This datapath unit runs the bit-test family of processor operations on one operand that has already been fetched. A request carries a bit number, the destination value, a flag telling whether the destination is a data register or a memory byte, a flag telling whether the bit number came from an immediate word or from a data register, the incoming condition flags and a 2-bit operation code. The unit samples the bit, updates the zero flag from that original bit, and then leaves the bit alone, inverts it, clears it or sets it.

Requests enter through a valid/ready handshake. The unit then stays busy for the number of cycles that the operation is modelled to cost. After that it presents the modified value, the new flags, a write-back enable and the cycle cost, and holds them until the consumer takes them. Effective-address work and bus traffic stay with the surrounding core.

Top module: `bitop_unit`

## Requirements
- R1: Operation code 0 leaves the operand unchanged, 1 inverts the selected bit, 2 forces it to 0 and 3 forces it to 1. All other bits of `out_result` equal `in_dest`.
- R2: `out_flags[2]` (zero) is 1 exactly when the selected bit of the operand was 0 before any change, whatever the incoming zero flag was.
- R3: The flags are packed {N, Z, V, C} in bits 3..0. Bits 3, 1 and 0 of `out_flags` equal those of `in_flags` at acceptance.
- R4: `out_wr_en` is 0 for operation code 0 and 1 for codes 1 to 3.
- R5: With `in_is_reg`=1 the operand is 32 bits wide and all five bits of `in_bitsel` pick the bit.
- R6: With `in_is_reg`=0 the operand is a byte. Only `in_bitsel[2:0]` picks the bit (bit number modulo 8), and bits 31..8 of `out_result` equal `in_dest`.
- R7: With `in_imm_src`=0 the cost is 4 cycles, plus 2 for a register destination, plus 4 for a nonzero operation code.
- R8: With `in_imm_src`=1 the register extra of 2 applies only for codes 0 to 2. Immediate register set costs 8 cycles.
- R9: `out_valid` rises exactly `out_cycles` rising edges after the accepting edge. `in_ready` stays low from acceptance until the result is taken.
- R10: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_result`, `out_flags`, `out_wr_en` and `out_cycles` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request |
| in_imm_src | input | 1 | Bit number taken from an immediate word |
| in_is_reg | input | 1 | Destination is a data register (32-bit), else a memory byte |
| in_op | input | 2 | 0 test, 1 invert, 2 clear, 3 set |
| in_bitsel | input | 5 | Bit number |
| in_dest | input | 32 | Destination operand value |
| in_flags | input | 4 | Incoming flags {N,Z,V,C} |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Modified operand |
| out_flags | output | 4 | Updated flags {N,Z,V,C} |
| out_wr_en | output | 1 | Result must be written back |
| out_cycles | output | 4 | Modelled cycle cost |

## Verification
All result fields appear together, exactly as many edges after the accepting edge as the cost reported in `out_cycles`: 4 to 10 edges, depending on destination kind, source form and operation code. The driver records the cycle number of the accepting edge with each expected item. The monitor samples on falling edges and checks that the first cycle with `out_valid` high lies that expected cost after acceptance. For some items the monitor keeps `out_ready` low for several cycles and checks on every stalled cycle that the presented result does not move before the full comparison.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [1:0] {
    BOP_TEST = 2'd0,
    BOP_FLIP = 2'd1,
    BOP_CLR  = 2'd2,
    BOP_SET  = 2'd3
  } bop_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_BUSY,
    SQ_DONE
  } seq_e;

  localparam int FLG_W = 4;
  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_V = 1;
  localparam int FLG_C = 0;

endpackage

// File: rtl/bitop_mask.sv
module bitop_mask #(
  parameter int DATA_W = 32,
  parameter int MEM_W  = 8,
  localparam int SEL_W = $clog2(DATA_W)
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic              is_reg,
  output logic [DATA_W-1:0] mask
);

  localparam int MEM_SEL_W = $clog2(MEM_W);

  // one-hot decode; a byte operand only sees the low selector bits
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i < MEM_W) begin : g_low
      assign mask[i] = is_reg ? (sel == SEL_W'(i))
                              : (sel[MEM_SEL_W-1:0] == MEM_SEL_W'(i));
    end else begin : g_high
      assign mask[i] = is_reg && (sel == SEL_W'(i));
    end
  end

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] dest,
  input  logic [DATA_W-1:0] mask,
  input  bop_e              op,
  input  logic [FLG_W-1:0]  flags_in,
  output logic [DATA_W-1:0] result,
  output logic [FLG_W-1:0]  flags_out,
  output logic              wr_en
);

  localparam logic [FLG_W-1:0] Z_BIT = FLG_W'(1) << FLG_Z;

  logic bit_clear;

  always_comb begin
    // sampled from the unmodified operand
    bit_clear = ~|(dest & mask);
    flags_out = (flags_in & ~Z_BIT) | (bit_clear ? Z_BIT : '0);
    unique case (op)
      BOP_TEST: result = dest;
      BOP_FLIP: result = dest ^ mask;
      BOP_CLR:  result = dest & ~mask;
      BOP_SET:  result = dest | mask;
      default:  result = dest;
    endcase
    wr_en = (op != BOP_TEST);
  end

endmodule

// File: rtl/bitop_cost.sv
module bitop_cost
  import bitop_pkg::*;
#(
  parameter int CYC_W    = 4,
  parameter int BASE_CYC = 4,
  parameter int REG_CYC  = 2,
  parameter int MOD_CYC  = 4
) (
  input  logic             imm_src,
  input  logic             is_reg,
  input  bop_e             op,
  output logic [CYC_W-1:0] cycles
);

  logic reg_extra;
  logic mod_extra;

  always_comb begin
    // the immediate form drops the register extra for set
    reg_extra = is_reg && !(imm_src && (op == BOP_SET));
    mod_extra = (op != BOP_TEST);
    cycles    = CYC_W'(BASE_CYC)
              + (reg_extra ? CYC_W'(REG_CYC) : '0)
              + (mod_extra ? CYC_W'(MOD_CYC) : '0);
  end

endmodule

// File: rtl/bitop_seq.sv
module bitop_seq
  import bitop_pkg::*;
#(
  parameter int CYC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CYC_W-1:0] cycles,
  input  logic             ack,
  output logic             idle,
  output logic             done
);

  seq_e             state_q, state_d;
  logic [CYC_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (start) begin
          state_d = SQ_BUSY;
          cnt_d   = cycles;
          cnt_en  = 1'b1;
        end
      end
      SQ_BUSY: begin
        cnt_d  = cnt_q - CYC_W'(1);
        cnt_en = 1'b1;
        if (cnt_q == CYC_W'(1)) state_d = SQ_DONE;
      end
      SQ_DONE: begin
        if (ack) state_d = SQ_IDLE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign idle = (state_q == SQ_IDLE);
  assign done = (state_q == SQ_DONE);

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int MEM_W    = 8,
  parameter int CYC_W    = 4,
  parameter int BASE_CYC = 4,
  parameter int REG_CYC  = 2,
  parameter int MOD_CYC  = 4,
  localparam int SEL_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_imm_src,
  input  logic              in_is_reg,
  input  logic [1:0]        in_op,
  input  logic [SEL_W-1:0]  in_bitsel,
  input  logic [DATA_W-1:0] in_dest,
  input  logic [3:0]        in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [3:0]        out_flags,
  output logic              out_wr_en,
  output logic [CYC_W-1:0]  out_cycles
);

  bop_e              op;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] res_d, res_q;
  logic [FLG_W-1:0]  flg_d, flg_q;
  logic              wr_d, wr_q;
  logic [CYC_W-1:0]  cyc_d, cyc_q;
  logic              idle;
  logic              done;
  logic              cap_en;

  assign op     = bop_e'(in_op);
  assign cap_en = in_valid && idle;

  bitop_mask #(
    .DATA_W (DATA_W),
    .MEM_W  (MEM_W)
  ) mask_i (
    .sel    (in_bitsel),
    .is_reg (in_is_reg),
    .mask   (mask)
  );

  bitop_alu #(
    .DATA_W (DATA_W)
  ) alu_i (
    .dest      (in_dest),
    .mask      (mask),
    .op        (op),
    .flags_in  (in_flags),
    .result    (res_d),
    .flags_out (flg_d),
    .wr_en     (wr_d)
  );

  bitop_cost #(
    .CYC_W    (CYC_W),
    .BASE_CYC (BASE_CYC),
    .REG_CYC  (REG_CYC),
    .MOD_CYC  (MOD_CYC)
  ) cost_i (
    .imm_src (in_imm_src),
    .is_reg  (in_is_reg),
    .op      (op),
    .cycles  (cyc_d)
  );

  bitop_seq #(
    .CYC_W (CYC_W)
  ) seq_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (cap_en),
    .cycles (cyc_d),
    .ack    (out_ready),
    .idle   (idle),
    .done   (done)
  );

  // result is computed at acceptance and held while the cost elapses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      flg_q <= '0;
      wr_q  <= 1'b0;
      cyc_q <= '0;
    end else if (cap_en) begin
      res_q <= res_d;
      flg_q <= flg_d;
      wr_q  <= wr_d;
      cyc_q <= cyc_d;
    end
  end

  assign in_ready   = idle;
  assign out_valid  = done;
  assign out_result = res_q;
  assign out_flags  = flg_q;
  assign out_wr_en  = wr_q;
  assign out_cycles = cyc_q;

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int DATA_W = 32,
  parameter int CYC_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_op,
  input logic [3:0]        in_flags,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic [3:0]        out_flags,
  input logic              out_wr_en,
  input logic [CYC_W-1:0]  out_cycles
);

  logic [CYC_W:0] lat_q;
  logic [3:0]     cap_flags_q;
  logic [1:0]     cap_op_q;
  logic           acc;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q       <= '0;
      cap_flags_q <= '0;
      cap_op_q    <= '0;
    end else if (acc) begin
      lat_q       <= '0;
      cap_flags_q <= in_flags;
      cap_op_q    <= in_op;
    end else if (!out_valid && !(&lat_q)) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  AST_LATENCY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_q == {1'b0, out_cycles}));  // R9

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);  // R9

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_flags)
                                   && $stable(out_wr_en) && $stable(out_cycles)));  // R10

  AST_NVC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_flags & 4'b1011) == (cap_flags_q & 4'b1011)));  // R3

  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_wr_en == (cap_op_q != 2'd0)));  // R4

endmodule

bind bitop_unit bitop_unit_chk #(
  .DATA_W (DATA_W),
  .CYC_W  (CYC_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .in_flags   (in_flags),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_flags  (out_flags),
  .out_wr_en  (out_wr_en),
  .out_cycles (out_cycles)
);

// File: tb/bitop_unit_tb_top.sv
module bitop_unit_tb_top;

  typedef struct {
    logic [31:0] res;
    logic [3:0]  flg;
    logic        wr;
    logic [3:0]  cyc;
    int          acc;
    int          stall;
    string       tag;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic        in_imm_src;
  logic        in_is_reg;
  logic [1:0]  in_op;
  logic [4:0]  in_bitsel;
  logic [31:0] in_dest;
  logic [3:0]  in_flags;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_result;
  logic [3:0]  out_flags;
  logic        out_wr_en;
  logic [3:0]  out_cycles;

  item_t items_q[$];
  int    errors = 0;
  int    checks = 0;
  int    cyc_cnt = 0;
  bit    done = 0;

  bitop_unit dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_imm_src (in_imm_src),
    .in_is_reg  (in_is_reg),
    .in_op      (in_op),
    .in_bitsel  (in_bitsel),
    .in_dest    (in_dest),
    .in_flags   (in_flags),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_result (out_result),
    .out_flags  (out_flags),
    .out_wr_en  (out_wr_en),
    .out_cycles (out_cycles)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic item_t model(input logic imm, input logic isreg, input logic [1:0] op,
                                  input logic [4:0] sel, input logic [31:0] dest,
                                  input logic [3:0] flags, input int stall, input string tag);
    item_t       it;
    logic [31:0] m;
    logic        z;
    int          c;
    m = isreg ? (32'h1 << sel) : (32'h1 << sel[2:0]);
    z = ((dest & m) == 32'h0);
    case (op)
      2'd0: it.res = dest;
      2'd1: it.res = dest ^ m;
      2'd2: it.res = dest & ~m;
      default: it.res = dest | m;
    endcase
    it.flg = {flags[3], z, flags[1:0]};
    it.wr  = (op != 2'd0);
    c = 4;
    if (isreg && !(imm && op == 2'd3)) c += 2;
    if (op != 2'd0) c += 4;
    it.cyc   = 4'(c);
    it.stall = stall;
    it.tag   = tag;
    it.acc   = 0;
    return it;
  endfunction

  task automatic send(input logic imm, input logic isreg, input logic [1:0] op,
                      input logic [4:0] sel, input logic [31:0] dest,
                      input logic [3:0] flags, input int stall, input string tag);
    item_t it;
    it = model(imm, isreg, op, sel, dest, flags, stall, tag);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid   = 1'b1;
    in_imm_src = imm;
    in_is_reg  = isreg;
    in_op      = op;
    in_bitsel  = sel;
    in_dest    = dest;
    in_flags   = flags;
    it.acc     = cyc_cnt + 1;
    items_q.push_back(it);
    @(negedge clk);
    in_valid   = 1'b0;
    in_dest    = 32'hDEAD_BEEF;
    in_flags   = 4'h0;
  endtask

  // monitor / scoreboard
  initial begin
    item_t       it;
    bit          seen;
    int          hold_left;
    logic [31:0] hold_res;
    logic [3:0]  hold_flg;
    out_ready = 1'b0;
    seen      = 0;
    hold_left = 0;
    hold_res  = '0;
    hold_flg  = '0;
    forever begin
      @(negedge clk);
      if (out_valid && rst_n) begin
        if (items_q.size() == 0) begin
          chk("R9 unexpected out_valid", 32'd1, 32'd0);
          out_ready = 1'b1;
        end else begin
          it = items_q[0];
          if (!seen) begin
            seen      = 1;
            hold_left = it.stall;
            hold_res  = out_result;
            hold_flg  = out_flags;
            chk({"R9 latency ", it.tag}, 32'(cyc_cnt - it.acc), 32'(it.cyc));
            chk("R9 in_ready low while result pending", {31'b0, in_ready}, 32'd0);
          end else begin
            chk("R10 held result", out_result, hold_res);
            chk("R10 held flags", {28'b0, out_flags}, {28'b0, hold_flg});
          end
          if (hold_left > 0) begin
            hold_left--;
            out_ready = 1'b0;
          end else begin
            chk({it.tag, " result"}, out_result, it.res);
            chk("R2 zero flag", {31'b0, out_flags[2]}, {31'b0, it.flg[2]});
            chk("R3 NVC flags", {28'b0, out_flags}, {28'b0, it.flg});
            chk("R4 write enable", {31'b0, out_wr_en}, {31'b0, it.wr});
            chk("R7/R8 cycles", {28'b0, out_cycles}, {28'b0, it.cyc});
            void'(items_q.pop_front());
            seen      = 0;
            out_ready = 1'b1;
          end
        end
      end else begin
        out_ready = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    in_valid   = 1'b0;
    in_imm_src = 1'b0;
    in_is_reg  = 1'b0;
    in_op      = 2'd0;
    in_bitsel  = '0;
    in_dest    = '0;
    in_flags   = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset in_ready", {31'b0, in_ready}, 32'd1);
    chk("R9 reset out_valid", {31'b0, out_valid}, 32'd0);
    rst_n = 1'b1;

    // R1 register operand, each code, dynamic source (R7)
    send(1'b0, 1'b1, 2'd0, 5'd7,  32'h0000_0080, 4'b1011, 0, "R1 test");
    send(1'b0, 1'b1, 2'd1, 5'd7,  32'h0000_0080, 4'b0000, 0, "R1 flip");
    send(1'b0, 1'b1, 2'd2, 5'd31, 32'h8000_0001, 4'b1001, 2, "R1 clear");
    send(1'b0, 1'b1, 2'd3, 5'd16, 32'h0000_0000, 4'b0110, 0, "R1 set");
    // R2 incoming Z set, bit is 1 -> Z must drop
    send(1'b0, 1'b1, 2'd0, 5'd3,  32'hFFFF_FFFF, 4'b0100, 0, "R2 test");
    // R5 register high bits
    send(1'b0, 1'b1, 2'd1, 5'd24, 32'h1234_5678, 4'b0010, 3, "R5 flip");
    send(1'b1, 1'b1, 2'd2, 5'd28, 32'hF000_0000, 4'b1111, 0, "R5 clear");
    // R6 byte operand: bit number modulo 8, upper bits untouched
    send(1'b0, 1'b0, 2'd3, 5'd13, 32'hAB00_0000, 4'b0001, 0, "R6 set");
    send(1'b0, 1'b0, 2'd1, 5'd31, 32'h5555_5580, 4'b1000, 1, "R6 flip");
    send(1'b1, 1'b0, 2'd0, 5'd10, 32'hFFFF_FF00, 4'b0000, 0, "R6 test");
    send(1'b1, 1'b0, 2'd2, 5'd0,  32'hFFFF_FFFF, 4'b0101, 0, "R6 clear");
    // R8 immediate register forms
    send(1'b1, 1'b1, 2'd3, 5'd4,  32'h0000_0000, 4'b0000, 0, "R8 set");
    send(1'b1, 1'b1, 2'd1, 5'd4,  32'h0000_0010, 4'b1010, 0, "R8 flip");
    send(1'b1, 1'b1, 2'd0, 5'd0,  32'h0000_0000, 4'b0011, 2, "R8 test");
    send(1'b0, 1'b0, 2'd3, 5'd2,  32'h0000_0004, 4'b1100, 0, "R7 set");

    while (items_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R9 idle after drain", {31'b0, in_ready}, 32'd1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule